// File: doc/BRIEF.md
# Serial Bus Mode Control and Rate Select

This block holds the control word of a two-wire serial interface and keeps the interface's operating mode in step with events on the bus. The word carries an interface enable, a receive-hold option, a four-bit rate code and two mode bits. The mode bits are `mst` (master/slave) and `trs` (transmit/receive). Software writes the word over a simple one-cycle write strobe and can read it back at any time.

The shift engine, the address comparator and the arbitration detector sit outside this block. They report arbitration loss, address-with-read match, overrun and receive-register reads as single-cycle pulses. The block applies these pulses to the mode bits, and hardware wins over a software write that lands in the same cycle. The block also decodes the rate code into a clock divide ratio and a data setup count for the clock generator. Both are registered so that they change on the same edge as the stored rate code.

Top module: `i2c_mode_ctrl`

## Requirements
- R1: After reset `rd_data` is 00h, `mode` is 00, `rx_inhibit` is 0, `scl_div` is 28 and `setup_cnt` is 10.
- R2: A cycle with `wr_en`=1 stores `wr_data`, which appears on `rd_data` after that edge. The bit layout is bit7 enable, bit6 receive-hold, bit5 `mst`, bit4 `trs` and bits3:0 rate code. `mode`={`mst`,`trs`}, where 00 is slave receive, 01 slave transmit, 10 master receive and 11 master transmit.
- R3: `ev_arb_lost` clears `mst` and `trs` on the next edge when enable=1, `mst`=1 and `fmt_sync`=0. With `fmt_sync`=1 it has no effect.
- R4: `ev_addr_rd` sets `trs` on the next edge when enable=1 and mode is 00. In any other mode it has no effect.
- R5: `ev_overrun` clears `mst` on the next edge when enable=1, mode is 10 and `fmt_sync`=1. With `fmt_sync`=0, or in any other mode, it has no effect.
- R6: When a qualifying hardware event and a write fall in the same cycle, `mst` and `trs` take the event's result, computed from the mode held before the edge. The other six bits take `wr_data`.
- R7: `scl_div` follows the stored rate code. With bit3=0, codes 0..7 give 28, 40, 48, 64, 80, 100, 112 and 128. With bit3=1, the same low codes give twice those values: 56, 80, 96, 128, 160, 200, 224 and 256.
- R8: `setup_cnt` is 10 when rate bit3 is 0 and 20 when it is 1. It updates on the same edge as the rate code.
- R9: `rx_inhibit` sets when `rx_read`=1 while enable=1, receive-hold=1 and `trs`=0. It clears on any write that leaves enable or receive-hold at 0, and the clear wins over a set in the same cycle.
- R10: `bus_drive` equals the stored enable bit. While enable=0, all mode events and `rx_read` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 8 | Control word write value |
| rd_data | output | 8 | Stored control word |
| fmt_sync | input | 1 | 1 = clock-synchronous format, 0 = two-wire bus format |
| ev_arb_lost | input | 1 | Arbitration-loss pulse |
| ev_addr_rd | input | 1 | Own address matched with read bit pulse |
| ev_overrun | input | 1 | Receive overrun pulse |
| rx_read | input | 1 | Receive data register read pulse |
| mode | output | 2 | {mst, trs} |
| bus_drive | output | 1 | Interface owns the bus pins |
| rx_inhibit | output | 1 | Next reception is held off |
| scl_div | output | 9 | Decoded clock divide ratio |
| setup_cnt | output | 5 | Slave-transmit data setup count |

## Verification
Every result of this block is due one edge after the stimulus that causes it. This holds for the stored word, the mode change from an event, the inhibit flag and the decoded divisor and setup count. None of them takes two edges, because the decode is fed from the next-state value. The bench drives each stimulus on a falling edge. It then samples every output 1 ns after the following rising edge and compares it with a model that it advanced by exactly one step. The checker properties use `|=>` with the same one-cycle offset.

// File: rtl/i2c_mode_pkg.sv
package i2c_mode_pkg;
  localparam int RATE_W  = 4;
  localparam int DIV_W   = 9;
  localparam int SETUP_W = 5;
  localparam int CTL_W   = 4 + RATE_W;

  typedef struct packed {
    logic              en;
    logic              rxhold;
    logic              mst;
    logic              trs;
    logic [RATE_W-1:0] rate;
  } ctl_t;

  // Low bank divisor; the high bank doubles it.
  function automatic logic [DIV_W-1:0] div_of(input logic [RATE_W-1:0] r);
    logic [DIV_W-1:0] base;
    case (r[2:0])
      3'd0:    base = DIV_W'(28);
      3'd1:    base = DIV_W'(40);
      3'd2:    base = DIV_W'(48);
      3'd3:    base = DIV_W'(64);
      3'd4:    base = DIV_W'(80);
      3'd5:    base = DIV_W'(100);
      3'd6:    base = DIV_W'(112);
      default: base = DIV_W'(128);
    endcase
    return r[RATE_W-1] ? (base << 1) : base;
  endfunction

  function automatic logic [SETUP_W-1:0] setup_of(input logic [RATE_W-1:0] r);
    return r[RATE_W-1] ? SETUP_W'(20) : SETUP_W'(10);
  endfunction
endpackage

// File: rtl/i2c_mode_seq.sv
module i2c_mode_seq
  import i2c_mode_pkg::*;
(
  input  ctl_t cur,
  input  logic fmt_sync,
  input  logic ev_arb_lost,
  input  logic ev_addr_rd,
  input  logic ev_overrun,
  output logic arb_hit,
  output logic adr_hit,
  output logic ovr_hit,
  output logic hw_hit,
  output logic hw_mst,
  output logic hw_trs
);
  // Qualify each event against the mode held now.
  assign arb_hit = ev_arb_lost && cur.en && cur.mst && !fmt_sync;
  assign ovr_hit = ev_overrun && cur.en && cur.mst && !cur.trs && fmt_sync;
  assign adr_hit = ev_addr_rd && cur.en && !cur.mst && !cur.trs;
  assign hw_hit  = arb_hit || ovr_hit || adr_hit;

  always_comb begin
    hw_mst = cur.mst;
    hw_trs = cur.trs;
    if (arb_hit) begin
      hw_mst = 1'b0;
      hw_trs = 1'b0;
    end else if (ovr_hit) begin
      hw_mst = 1'b0;
    end else if (adr_hit) begin
      hw_trs = 1'b1;
    end
  end
endmodule

// File: rtl/i2c_mode_regs.sv
module i2c_mode_regs
  import i2c_mode_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_data,
  input  logic             hw_hit,
  input  logic             hw_mst,
  input  logic             hw_trs,
  input  logic             rx_read,
  output ctl_t             ctl_q,
  output ctl_t             ctl_d,
  output logic             inh_set,
  output logic             inh_clr,
  output logic             rx_inhibit
);
  ctl_t wr_word;
  assign wr_word = ctl_t'(wr_data);

  always_comb begin
    ctl_d = wr_en ? wr_word : ctl_q;
    if (hw_hit) begin
      ctl_d.mst = hw_mst;
      ctl_d.trs = hw_trs;
    end
  end

  assign inh_clr = wr_en && !(wr_word.en && wr_word.rxhold);
  assign inh_set = rx_read && ctl_q.en && ctl_q.rxhold && !ctl_q.trs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q      <= '0;
      rx_inhibit <= 1'b0;
    end else begin
      ctl_q <= ctl_d;
      if (inh_clr)      rx_inhibit <= 1'b0;
      else if (inh_set) rx_inhibit <= 1'b1;
    end
  end
endmodule

// File: rtl/i2c_rate_decode.sv
module i2c_rate_decode
  import i2c_mode_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RATE_W-1:0]  rate_d,
  output logic [DIV_W-1:0]   scl_div,
  output logic [SETUP_W-1:0] setup_cnt
);
  // Fed from next-state rate so outputs align with the stored code.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_div   <= div_of('0);
      setup_cnt <= setup_of('0);
    end else begin
      scl_div   <= div_of(rate_d);
      setup_cnt <= setup_of(rate_d);
    end
  end
endmodule

// File: rtl/i2c_mode_ctrl.sv
module i2c_mode_ctrl
  import i2c_mode_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [CTL_W-1:0]   wr_data,
  output logic [CTL_W-1:0]   rd_data,
  input  logic               fmt_sync,
  input  logic               ev_arb_lost,
  input  logic               ev_addr_rd,
  input  logic               ev_overrun,
  input  logic               rx_read,
  output logic [1:0]         mode,
  output logic               bus_drive,
  output logic               rx_inhibit,
  output logic [DIV_W-1:0]   scl_div,
  output logic [SETUP_W-1:0] setup_cnt
);
  ctl_t ctl_q, ctl_d;
  logic arb_hit, adr_hit, ovr_hit, hw_hit, hw_mst, hw_trs;
  logic inh_set, inh_clr;

  i2c_mode_seq u_seq (
    .cur(ctl_q), .fmt_sync(fmt_sync),
    .ev_arb_lost(ev_arb_lost), .ev_addr_rd(ev_addr_rd), .ev_overrun(ev_overrun),
    .arb_hit(arb_hit), .adr_hit(adr_hit), .ovr_hit(ovr_hit),
    .hw_hit(hw_hit), .hw_mst(hw_mst), .hw_trs(hw_trs)
  );

  i2c_mode_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .hw_hit(hw_hit), .hw_mst(hw_mst), .hw_trs(hw_trs), .rx_read(rx_read),
    .ctl_q(ctl_q), .ctl_d(ctl_d), .inh_set(inh_set), .inh_clr(inh_clr),
    .rx_inhibit(rx_inhibit)
  );

  i2c_rate_decode u_rate (
    .clk(clk), .rst_n(rst_n), .rate_d(ctl_d.rate),
    .scl_div(scl_div), .setup_cnt(setup_cnt)
  );

  assign rd_data   = ctl_q;
  assign mode      = {ctl_q.mst, ctl_q.trs};
  assign bus_drive = ctl_q.en;
endmodule

// File: rtl/i2c_mode_ctrl_chk.sv
module i2c_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       fmt_sync,
  input logic       ev_arb_lost,
  input logic       ev_addr_rd,
  input logic       ev_overrun,
  input logic       rx_read,
  input logic [1:0] mode,
  input logic       bus_drive,
  input logic       rx_inhibit,
  input logic [8:0] scl_div,
  input logic [4:0] setup_cnt,
  input logic       arb_hit,
  input logic       adr_hit,
  input logic       ovr_hit
);
  // R3
  arb_clears_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_arb_lost && bus_drive && mode[1] && !fmt_sync) |=> (mode == 2'b00));
  // R4
  addr_sets_trs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_addr_rd && bus_drive && mode == 2'b00) |=> mode[0]);
  // R5
  overrun_drops_mst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_overrun && bus_drive && mode == 2'b10 && fmt_sync) |=> !mode[1]);
  // R10
  idle_events_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_drive && !wr_en) |=> $stable(mode) && $stable(rx_inhibit));
  // R8
  setup_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    setup_cnt == (rd_data[3] ? 5'd20 : 5'd10));
  // R7
  div_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[3] |-> (scl_div >= 9'd56 && scl_div[0] == 1'b0));
  // R9
  inhibit_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_inhibit) |-> $past(rx_read && rd_data[7] && rd_data[6] && !rd_data[4]));
  // R6
  single_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({arb_hit, adr_hit, ovr_hit}) <= 1);
endmodule

bind i2c_mode_ctrl i2c_mode_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .fmt_sync(fmt_sync), .ev_arb_lost(ev_arb_lost), .ev_addr_rd(ev_addr_rd),
  .ev_overrun(ev_overrun), .rx_read(rx_read), .mode(mode), .bus_drive(bus_drive),
  .rx_inhibit(rx_inhibit), .scl_div(scl_div), .setup_cnt(setup_cnt),
  .arb_hit(arb_hit), .adr_hit(adr_hit), .ovr_hit(ovr_hit)
);

// File: tb/tb_i2c_mode_ctrl.sv
`timescale 1ns/1ps
module tb_i2c_mode_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic fmt_sync = 1'b0, ev_arb_lost = 1'b0, ev_addr_rd = 1'b0, ev_overrun = 1'b0, rx_read = 1'b0;
  logic [7:0] rd_data;
  logic [1:0] mode;
  logic bus_drive, rx_inhibit;
  logic [8:0] scl_div;
  logic [4:0] setup_cnt;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [7:0] m_reg = '0;
  logic m_inh = 1'b0;

  always #4 clk = ~clk;

  i2c_mode_ctrl dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .fmt_sync(fmt_sync), .ev_arb_lost(ev_arb_lost), .ev_addr_rd(ev_addr_rd),
    .ev_overrun(ev_overrun), .rx_read(rx_read), .mode(mode), .bus_drive(bus_drive),
    .rx_inhibit(rx_inhibit), .scl_div(scl_div), .setup_cnt(setup_cnt)
  );

  function automatic int exp_div(input logic [3:0] r);
    case (r)
      4'h0: return 28;  4'h1: return 40;  4'h2: return 48;  4'h3: return 64;
      4'h4: return 80;  4'h5: return 100; 4'h6: return 112; 4'h7: return 128;
      4'h8: return 56;  4'h9: return 80;  4'hA: return 96;  4'hB: return 128;
      4'hC: return 160; 4'hD: return 200; 4'hE: return 224; default: return 256;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all(input string mtag);
    chk("R2 rd_data", int'(rd_data), int'(m_reg));
    chk(mtag, int'(mode), int'(m_reg[5:4]));
    chk("R10 bus_drive", int'(bus_drive), int'(m_reg[7]));
    chk("R9 rx_inhibit", int'(rx_inhibit), int'(m_inh));
    chk("R7 scl_div", int'(scl_div), exp_div(m_reg[3:0]));
    chk("R8 setup_cnt", int'(setup_cnt), m_reg[3] ? 20 : 10);
  endtask

  task automatic step(input string mtag, input logic w, input logic [7:0] d,
                      input logic arb, input logic adr, input logic ovr,
                      input logic sy, input logic rr);
    logic [7:0] nxt;
    logic a_q, o_q, d_q, ninh;
    @(negedge clk);
    wr_en = w; wr_data = d; ev_arb_lost = arb; ev_addr_rd = adr;
    ev_overrun = ovr; fmt_sync = sy; rx_read = rr;
    a_q = arb && m_reg[7] && m_reg[5] && !sy;
    o_q = ovr && m_reg[7] && m_reg[5:4] == 2'b10 && sy;
    d_q = adr && m_reg[7] && m_reg[5:4] == 2'b00;
    nxt = w ? d : m_reg;
    if (a_q || o_q)  nxt[5:4] = 2'b00;
    else if (d_q)    nxt[5:4] = 2'b01;
    ninh = m_inh;
    if (w && !(d[7] && d[6]))                          ninh = 1'b0;
    else if (rr && m_reg[7] && m_reg[6] && !m_reg[4])  ninh = 1'b1;
    @(posedge clk);
    #1;
    m_reg = nxt;
    m_inh = ninh;
    check_all(mtag);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 rd_data", int'(rd_data), 0);
    chk("R1 mode", int'(mode), 0);
    chk("R1 rx_inhibit", int'(rx_inhibit), 0);
    chk("R1 scl_div", int'(scl_div), 28);
    chk("R1 setup_cnt", int'(setup_cnt), 10);
    @(negedge clk);
    rst_n = 1'b1;

    step("R2 mode", 1, 8'hB0, 0, 0, 0, 0, 0);          // master transmit
    step("R3 mode", 0, 8'h00, 1, 0, 0, 1, 0);          // sync format: ignored
    step("R3 mode", 0, 8'h00, 1, 0, 0, 0, 0);          // falls to slave receive
    step("R2 mode", 1, 8'hA0, 0, 0, 0, 0, 0);          // master receive
    step("R5 mode", 0, 8'h00, 0, 0, 1, 0, 0);          // bus format: ignored
    step("R5 mode", 0, 8'h00, 0, 0, 1, 1, 0);          // clears mst
    step("R4 mode", 0, 8'h00, 0, 1, 0, 0, 0);          // slave transmit
    step("R4 mode", 0, 8'h00, 0, 1, 0, 0, 0);          // already 01: ignored
    step("R6 mode", 1, 8'hB5, 1, 0, 0, 0, 0);          // arb wins? mst=0 now, so write wins
    step("R6 mode", 1, 8'h8A, 1, 0, 0, 0, 0);          // arb wins over write
    step("R6 mode", 1, 8'hE3, 0, 1, 0, 0, 0);          // addr wins, rate from write
    step("R10 mode", 1, 8'h20, 0, 0, 0, 0, 0);         // disabled, master receive
    step("R10 mode", 0, 8'h00, 1, 1, 1, 1, 1);         // all ignored
    step("R9 mode", 1, 8'hC0, 0, 0, 0, 0, 0);
    step("R9 mode", 0, 8'h00, 0, 0, 0, 0, 1);          // inhibit sets
    step("R9 mode", 1, 8'h80, 0, 0, 0, 0, 0);          // inhibit clears
    step("R9 mode", 1, 8'hC0, 0, 0, 0, 0, 0);
    step("R9 mode", 1, 8'h40, 0, 0, 0, 0, 1);          // clear wins over set
    for (int r = 0; r < 16; r++) step("R7 mode", 1, 8'h80 | 8'(r), 0, 0, 0, 0, 0);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] x;
      x = $urandom;
      step("R2 mode", x[3:0] < 4'd5, x[15:8], x[16] & x[17], x[18] & x[19],
           x[20] & x[21], x[22], x[23] & x[24]);
    end

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule